// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by fetching two 32-bit descriptors from memory. The first fetch comes from a directory, and the second from a page table that the directory descriptor names. A client sends one translation request with a valid/ready handshake. The block issues word reads on a simple request/response memory port. It then returns one result on a second valid/ready channel: the physical address with its attributes, or a fault code. Alongside the result it pulses a fault report aimed at a control block. The report carries the virtual address, the direction and the fault kind.

Each descriptor is 32 bits wide. The frame number sits in the upper twenty bits, above the 4 KiB page offset, and flags sit in the low bits. In the extended mode, two low nibbles of each descriptor carry physical address bits 39:32, which gives a 40-bit physical space. In the base mode those bits are zero. The `ext_mode` input picks the mode for each request.

Back-pressure rules:
- A request is taken only when `req_valid` and `req_ready` are both high at a clock edge.
- A memory read is issued when `mem_req_valid` and `mem_req_ready` are both high. Until then its address stays stable.
- The memory response has no ready signal. While the walker waits for a descriptor, it takes `mem_rsp_valid` on any cycle.
- A result stays on the result channel, unchanged, until `res_ready` takes it.

Top module: `dva_walker`

## Requirements
- R1: The directory read address is {dir_frame, va[31:22], 2'b00}. The page-table read address is {table frame, va[21:12], 2'b00}.
- R2: A directory descriptor gives the table frame in bits 31:12 and its valid flag in bit 0. In base mode, bits 11:1 have no effect on the table frame.
- R3: In extended mode, descriptor bits 11:8 become physical bits 35:32 and bits 7:4 become bits 39:36, at both levels. In base mode, physical bits 39:32 are zero.
- R4: A successful walk returns res_status 0 and res_pa = {page frame, va[11:0]}.
- R5: A descriptor with bit 0 clear ends the walk with res_status 1 (page fault). No page-table read follows a bad directory descriptor. flt_valid pulses for exactly one cycle, in the first result cycle, with flt_va = va and flt_write = the request direction.
- R6: A write to a page whose bit 2 is clear, or a read from a page whose bit 1 is clear, gives res_status 1.
- R7: An error response on either read gives res_status 2 (bus error) and flt_bus_err 1.
- R8: In base mode, res_attr equals page descriptor bits 8:1 and res_secure is 0. In extended mode, res_attr is {5'b0, bits 3:1} and res_secure equals bit 3.
- R9: Only one walk is in flight at a time. busy rises on the cycle after a request is accepted and falls after the result handshake. req_ready is high only while the block is idle.
- R10: While stall is high, req_ready stays low. A walk that has already started still runs to completion.
- R11: An unaccepted memory request keeps its address, and an unaccepted result keeps its values.
- R12: After reset, busy, res_valid, mem_req_valid and flt_valid are 0, and req_ready is 1 when stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 = 40-bit descriptor format; sampled when a request is accepted |
| dir_frame | input | 28 | Physical frame of the directory; sampled when a request is accepted |
| stall | input | 1 | Blocks acceptance of new requests |
| busy | output | 1 | A walk is in progress or its result is pending |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can take a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 40 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Read response carries an error |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Client takes the result |
| res_pa | output | 40 | Translated physical address; zero on a fault |
| res_status | output | 2 | 0 ok, 1 page fault, 2 bus error |
| res_attr | output | 8 | Page attribute flags |
| res_secure | output | 1 | Security flag of the page (extended mode) |
| flt_valid | output | 1 | One-cycle fault event |
| flt_bus_err | output | 1 | Fault is a bus error rather than a page fault |
| flt_va | output | 32 | Virtual address of the walk |
| flt_write | output | 1 | Direction of the faulting access |

## Verification
The properties assume that the memory side never returns a response unless a read is outstanding, and that the client deasserts nothing it has not had accepted. The bench serves every read itself: it replies exactly once, one cycle after each accepted read, and never replies spontaneously. The bench also holds `req_valid` and its payload steady until it sees `req_ready`. It changes `stall` only on falling edges, so that stall can only gate acceptance, which is what the property about stall relies on.

// File: rtl/dva_walk_pkg.sv
package dva_walk_pkg;

  typedef enum logic [1:0] {
    WS_OK     = 2'd0,
    WS_PFAULT = 2'd1,
    WS_BUSERR = 2'd2
  } walk_status_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_PG_REQ,
    ST_PG_WAIT,
    ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic valid;
    logic rd;
    logic wr;
    logic sec;
  } ent_flags_t;

endpackage

// File: rtl/dva_entry_dec.sv
// Splits one 32-bit descriptor into its physical frame, permission flags and
// attributes. The wide variant folds two low nibbles into the frame when the
// extended format is active.
module dva_entry_dec
  import dva_walk_pkg::*;
#(
  parameter int unsigned FRM_W = 28,
  parameter int unsigned PG_SH = 12,
  parameter int unsigned ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             ext,
  output logic [FRM_W-1:0] frame,
  output ent_flags_t       flags,
  output logic [7:0]       attr
);
  localparam int unsigned LOW_W = ENT_W - PG_SH;

  logic [LOW_W-1:0] low_frame;
  assign low_frame   = entry[ENT_W-1:PG_SH];
  assign flags.valid = entry[0];
  assign flags.rd    = entry[1];
  assign flags.wr    = entry[2];

  generate
    if (FRM_W >= LOW_W + 8) begin : g_wide
      logic [7:0] hi_bits;
      assign hi_bits   = ext ? {entry[7:4], entry[11:8]} : 8'h00;
      assign frame     = FRM_W'({hi_bits, low_frame});
      assign flags.sec = ext & entry[3];
      assign attr      = ext ? {5'b0, entry[3:1]} : entry[8:1];
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^{ext, entry[11:9]};
      assign frame     = FRM_W'(low_frame);
      assign flags.sec = 1'b0;
      assign attr      = entry[8:1];
    end
  endgenerate

endmodule

// File: rtl/dva_addr_gen.sv
// Forms a descriptor byte address from a table frame and the index field
// of the virtual page number that belongs to the current level.
module dva_addr_gen #(
  parameter int unsigned FRM_W = 28,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned PG_SH = 12
) (
  input  logic [FRM_W-1:0]   tbl_frame,
  input  logic [2*IDX_W-1:0] vpn,
  input  logic               second_lvl,
  output logic [FRM_W+PG_SH-1:0] addr
);
  localparam int unsigned ENT_SH = PG_SH - IDX_W;

  logic [IDX_W-1:0] idx;
  assign idx  = second_lvl ? vpn[IDX_W-1:0] : vpn[2*IDX_W-1:IDX_W];
  assign addr = {tbl_frame, idx, {ENT_SH{1'b0}}};

endmodule

// File: rtl/dva_walk_ctl.sv
// Sequencer: accepts one request, runs the two descriptor reads and holds
// the outcome until the client takes it.
module dva_walk_ctl
  import dva_walk_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned FRM_W = 28,
  parameter int unsigned OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_ext,
  input  logic [FRM_W-1:0] dir_frame,
  input  logic             stall,
  output logic             busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             second_lvl,
  output logic [FRM_W-1:0] tbl_frame,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [FRM_W-1:0] ent_frame,
  input  ent_flags_t       ent_flags,
  input  logic [7:0]       ent_attr,
  output logic             ext_q,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [FRM_W+OFF_W-1:0] res_pa,
  output logic [1:0]       res_status,
  output logic [7:0]       res_attr,
  output logic             res_secure,
  output logic             flt_valid,
  output logic             flt_bus_err,
  output logic [VA_W-1:0]  flt_va,
  output logic             flt_write
);
  walk_state_e  state;
  walk_status_e st_q, fin_st;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [FRM_W-1:0] frm_q;
  logic [FRM_W+OFF_W-1:0] pa_q;
  logic [7:0]       attr_q;
  logic             sec_q;
  logic             flt_q;
  logic             at_page, rsp_take, perm_bad, finish, accept;

  assign at_page  = (state == ST_PG_WAIT);
  assign rsp_take = mem_rsp_valid && (state == ST_DIR_WAIT || at_page);
  assign perm_bad = wr_q ? !ent_flags.wr : !ent_flags.rd;
  assign accept   = req_valid && req_ready;

  always_comb begin
    if (mem_rsp_err)                  fin_st = WS_BUSERR;
    else if (!ent_flags.valid)        fin_st = WS_PFAULT;
    else if (at_page && perm_bad)     fin_st = WS_PFAULT;
    else                              fin_st = WS_OK;
  end

  assign finish = rsp_take && (at_page || fin_st != WS_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      st_q   <= WS_OK;
      va_q   <= '0;
      wr_q   <= 1'b0;
      ext_q  <= 1'b0;
      frm_q  <= '0;
      pa_q   <= '0;
      attr_q <= '0;
      sec_q  <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      flt_q <= 1'b0;
      if (finish) begin
        state  <= ST_DONE;
        st_q   <= fin_st;
        flt_q  <= (fin_st != WS_OK);
        if (fin_st == WS_OK) begin
          pa_q   <= {ent_frame, va_q[OFF_W-1:0]};
          attr_q <= ent_attr;
          sec_q  <= ent_flags.sec;
        end else begin
          pa_q   <= '0;
          attr_q <= '0;
          sec_q  <= 1'b0;
        end
      end else begin
        unique case (state)
          ST_IDLE: if (accept) begin
            va_q  <= req_va;
            wr_q  <= req_write;
            ext_q <= req_ext;
            frm_q <= dir_frame;
            state <= ST_DIR_REQ;
          end
          ST_DIR_REQ: if (mem_req_ready) state <= ST_DIR_WAIT;
          ST_DIR_WAIT: if (rsp_take) begin
            frm_q <= ent_frame;
            state <= ST_PG_REQ;
          end
          ST_PG_REQ: if (mem_req_ready) state <= ST_PG_WAIT;
          ST_PG_WAIT: ;
          ST_DONE: if (res_ready) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign req_ready     = (state == ST_IDLE) && !stall;
  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_DIR_REQ) || (state == ST_PG_REQ);
  assign second_lvl    = (state == ST_PG_REQ);
  assign tbl_frame     = frm_q;
  assign res_valid     = (state == ST_DONE);
  assign res_pa        = pa_q;
  assign res_status    = st_q;
  assign res_attr      = attr_q;
  assign res_secure    = sec_q;
  assign flt_valid     = flt_q;
  assign flt_bus_err   = (st_q == WS_BUSERR);
  assign flt_va        = va_q;
  assign flt_write     = wr_q;

endmodule

// File: rtl/dva_walker.sv
module dva_walker #(
  parameter int unsigned PA_W  = 40,
  parameter int unsigned PG_SH = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ext_mode,
  input  logic [PA_W-PG_SH-1:0]  dir_frame,
  input  logic                   stall,
  output logic                   busy,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [2*(PG_SH-2)+PG_SH-1:0] req_va,
  input  logic                   req_write,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [PA_W-1:0]        mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [31:0]            mem_rsp_data,
  input  logic                   mem_rsp_err,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [PA_W-1:0]        res_pa,
  output logic [1:0]             res_status,
  output logic [7:0]             res_attr,
  output logic                   res_secure,
  output logic                   flt_valid,
  output logic                   flt_bus_err,
  output logic [2*(PG_SH-2)+PG_SH-1:0] flt_va,
  output logic                   flt_write
);
  import dva_walk_pkg::*;

  localparam int unsigned IDX_W = PG_SH - 2;
  localparam int unsigned VA_W  = 2 * IDX_W + PG_SH;
  localparam int unsigned FRM_W = PA_W - PG_SH;

  logic             ext_q, second_lvl;
  logic [FRM_W-1:0] tbl_frame, ent_frame;
  ent_flags_t       ent_flags;
  logic [7:0]       ent_attr;

  dva_entry_dec #(.FRM_W(FRM_W), .PG_SH(PG_SH), .ENT_W(32)) u_dec (
    .entry (mem_rsp_data),
    .ext   (ext_q),
    .frame (ent_frame),
    .flags (ent_flags),
    .attr  (ent_attr)
  );

  dva_addr_gen #(.FRM_W(FRM_W), .IDX_W(IDX_W), .PG_SH(PG_SH)) u_agen (
    .tbl_frame  (tbl_frame),
    .vpn        (flt_va[VA_W-1:PG_SH]),
    .second_lvl (second_lvl),
    .addr       (mem_req_addr)
  );

  dva_walk_ctl #(.VA_W(VA_W), .FRM_W(FRM_W), .OFF_W(PG_SH)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .req_write     (req_write),
    .req_ext       (ext_mode),
    .dir_frame     (dir_frame),
    .stall         (stall),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .second_lvl    (second_lvl),
    .tbl_frame     (tbl_frame),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .ent_frame     (ent_frame),
    .ent_flags     (ent_flags),
    .ent_attr      (ent_attr),
    .ext_q         (ext_q),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_pa        (res_pa),
    .res_status    (res_status),
    .res_attr      (res_attr),
    .res_secure    (res_secure),
    .flt_valid     (flt_valid),
    .flt_bus_err   (flt_bus_err),
    .flt_va        (flt_va),
    .flt_write     (flt_write)
  );

endmodule

// File: rtl/dva_walker_chk.sv
module dva_walker_chk #(
  parameter int unsigned PA_W = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            busy,
  input logic            stall,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            res_valid,
  input logic            res_ready,
  input logic [PA_W-1:0] res_pa,
  input logic [1:0]      res_status,
  input logic            flt_valid,
  input logic            flt_bus_err
);

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy);

  a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  a_r9_one_read_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !req_ready);

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r11_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_status));

  a_r5_fault_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> res_valid && res_status != 2'd0);

  a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> !flt_valid);

  a_r7_bus_kind: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && flt_bus_err |-> res_status == 2'd2);

endmodule

bind dva_walker dva_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .busy          (busy),
  .stall         (stall),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_pa        (res_pa),
  .res_status    (res_status),
  .flt_valid     (flt_valid),
  .flt_bus_err   (flt_bus_err)
);

// File: tb/dva_walker_bench.sv
`timescale 1ns/1ps
module dva_walker_bench;

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        ext;
    logic [31:0] dte;
    logic [31:0] pte;
    logic        derr;
    logic        perr;
    logic [1:0]  st;
    logic [39:0] pa;
    logic [7:0]  attr;
    logic        sec;
  } vec_t;

  localparam logic [27:0] DIRF = 28'hC00_0040;
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_1ABC, 1'b0, 1'b0, 32'h0012_3001, 32'h0ABC_D003, 1'b0, 1'b0, 2'd0, 40'h00_0ABC_DABC, 8'h01, 1'b0},
    '{32'hFFC0_3123, 1'b1, 1'b0, 32'h0000_1FFF, 32'h8765_4007, 1'b0, 1'b0, 2'd0, 40'h00_8765_4123, 8'h03, 1'b0},
    '{32'h1234_5678, 1'b0, 1'b1, 32'h0040_0A51, 32'hCAFE_E37B, 1'b0, 1'b0, 2'd0, 40'h73_CAFE_E678, 8'h05, 1'b1},
    '{32'h0080_0000, 1'b1, 1'b0, 32'h0000_5000, 32'h0000_0000, 1'b0, 1'b0, 2'd1, 40'h0, 8'h00, 1'b0},
    '{32'h0040_2000, 1'b0, 1'b0, 32'h0012_3001, 32'h0ABC_D006, 1'b0, 1'b0, 2'd1, 40'h0, 8'h00, 1'b0},
    '{32'h0040_3010, 1'b1, 1'b0, 32'h0012_3001, 32'h0ABC_D003, 1'b0, 1'b0, 2'd1, 40'h0, 8'h00, 1'b0},
    '{32'h0040_4020, 1'b0, 1'b0, 32'h0012_3001, 32'h0ABC_D005, 1'b0, 1'b0, 2'd1, 40'h0, 8'h00, 1'b0},
    '{32'h0100_0000, 1'b0, 1'b0, 32'h0012_3001, 32'h0000_0000, 1'b1, 1'b0, 2'd2, 40'h0, 8'h00, 1'b0},
    '{32'h0100_5000, 1'b1, 1'b0, 32'h0012_3001, 32'h0ABC_D007, 1'b0, 1'b1, 2'd2, 40'h0, 8'h00, 1'b0},
    '{32'h0000_0FFF, 1'b0, 1'b0, 32'h0000_3001, 32'h0000_2FF7, 1'b0, 1'b0, 2'd0, 40'h00_0000_2FFF, 8'hFB, 1'b0},
    '{32'hFFFF_F000, 1'b1, 1'b1, 32'h0000_0F01, 32'h0001_1005, 1'b0, 1'b0, 2'd0, 40'h00_0001_1000, 8'h02, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0;
  logic [27:0] dir_frame = DIRF;
  logic        stall = 1'b0;
  logic        busy;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [39:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [39:0] res_pa;
  logic [1:0]  res_status;
  logic [7:0]  res_attr;
  logic        res_secure;
  logic        flt_valid;
  logic        flt_bus_err;
  logic [31:0] flt_va;
  logic        flt_write;

  int n_checks = 0;
  int n_fail   = 0;
  int hs_cnt   = 0;
  int cyc      = 0;

  always #10 clk = ~clk;

  dva_walker u_dva_walker (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .dir_frame(dir_frame),
    .stall(stall), .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err), .res_valid(res_valid), .res_ready(res_ready),
    .res_pa(res_pa), .res_status(res_status), .res_attr(res_attr),
    .res_secure(res_secure), .flt_valid(flt_valid), .flt_bus_err(flt_bus_err),
    .flt_va(flt_va), .flt_write(flt_write)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_valid && mem_req_ready) hs_cnt <= hs_cnt + 1;
    if (cyc > 50000) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Table frame expected from a directory descriptor (R2, R3).
  function automatic logic [27:0] exp_frame(input logic [31:0] d, input logic ext);
    return ext ? {d[7:4], d[11:8], d[31:12]} : {8'h00, d[31:12]};
  endfunction

  task automatic serve(input logic [39:0] exp_addr, input logic [31:0] data,
                       input logic err, input int waitc, input string tag);
    int t = 0;
    while (!mem_req_valid && t < 40) begin @(negedge clk); t++; end
    check(mem_req_valid && mem_req_addr == exp_addr, tag, mem_req_addr, exp_addr);
    for (int k = 0; k < waitc; k++) begin
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == exp_addr, "R11 held read", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    mem_rsp_err   = err;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
  endtask

  task automatic run(input vec_t v, input int mem_wait, input int res_wait, input bit stall_mid);
    int t = 0;
    int hs0;
    logic [39:0] pa0;
    logic [1:0]  st0;
    @(negedge clk);
    req_va = v.va; req_write = v.wr; ext_mode = v.ext; req_valid = 1'b1;
    while (!req_ready && t < 20) begin @(negedge clk); t++; end
    hs0 = hs_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    ext_mode  = ~v.ext;
    check(busy && !req_ready, "R9 busy after accept", {busy, req_ready}, 2'b10);
    if (stall_mid) stall = 1'b1;
    serve({DIRF, v.va[31:22], 2'b00}, v.dte, v.derr, mem_wait, "R1 directory address");
    if (!v.derr && v.dte[0])
      serve({exp_frame(v.dte, v.ext), v.va[21:12], 2'b00}, v.pte, v.perr, 0, "R1 table address");
    t = 0;
    while (!res_valid && t < 40) begin @(negedge clk); t++; end
    check(res_status == v.st, v.st == 2 ? "R7 status" : (v.st == 1 ? "R5 R6 status" : "R4 status"),
          res_status, v.st);
    check(flt_valid == (v.st != 0), "R5 fault pulse", flt_valid, v.st != 0);
    if (v.st == 0) begin
      check(res_pa == v.pa, "R4 R3 physical address", res_pa, v.pa);
      check(res_attr == v.attr && res_secure == v.sec, "R8 attributes",
            {res_attr, res_secure}, {v.attr, v.sec});
    end else begin
      check(flt_va == v.va && flt_write == v.wr && flt_bus_err == (v.st == 2),
            "R5 R7 fault report", {flt_va, flt_write, flt_bus_err},
            {v.va, v.wr, v.st == 2});
    end
    check(hs_cnt - hs0 == ((!v.derr && v.dte[0]) ? 2 : 1), "R5 read count",
          hs_cnt - hs0, (!v.derr && v.dte[0]) ? 2 : 1);
    pa0 = res_pa; st0 = res_status;
    for (int k = 0; k < res_wait; k++) begin
      @(negedge clk);
      check(res_valid && res_pa == pa0 && res_status == st0 && !flt_valid,
            "R11 held result", {res_valid, res_pa, flt_valid}, {1'b1, pa0, 1'b0});
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!busy && !res_valid, "R9 idle after result", {busy, res_valid}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(!busy && !res_valid && !mem_req_valid && !flt_valid && req_ready, "R12 reset state",
          {busy, res_valid, mem_req_valid, flt_valid, req_ready}, 5'b00001);

    for (int i = 0; i < NV; i++) run(VECS[i], 0, 0, 1'b0);

    // R11 back-pressure on both channels
    run(VECS[2], 3, 3, 1'b0);
    run(VECS[5], 2, 2, 1'b0);

    // R10 stall blocks acceptance
    @(negedge clk);
    stall = 1'b1; req_valid = 1'b1; req_va = VECS[0].va; req_write = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!req_ready && !busy && !mem_req_valid, "R10 stall holds off",
            {req_ready, busy, mem_req_valid}, 3'b000);
    end
    req_valid = 1'b0; stall = 1'b0;
    // R10 walk started before stall completes
    run(VECS[1], 1, 0, 1'b1);
    req_valid = 1'b1;
    @(negedge clk);
    check(!req_ready && !busy, "R10 stall after walk", {req_ready, busy}, 2'b00);
    req_valid = 1'b0; stall = 1'b0;
    @(negedge clk);
    check(req_ready, "R12 ready when stall clears", req_ready, 1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule